// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block takes a single asynchronous serial line that rests at logic one and recovers characters from it. Each character is framed as one low start bit, seven data bits sent least significant bit first, one parity bit and one high stop bit. The raw line first passes through a chain of flip-flops clocked by the local clock, since it can change at any moment relative to that clock. A falling edge seen while the receiver is idle begins a character. A down-counter then times the mid-point of every following bit period and samples the line there.

The bit period in local clocks is a parameter, `BIT_CLKS`. The first sample falls `BIT_CLKS/2` clocks after the detected edge, and every later sample follows one full period after the one before. The counter is reloaded at every start edge, so rate mismatch between sender and receiver only builds up over a single character. When the stop bit has been sampled, the receiver presents the character together with a parity error flag and a framing error flag, and raises a one-clock valid strobe. The stream output has no back-pressure because a serial line cannot be paused. The consumer must take `rx_data` and the flags in the cycle `rx_valid` is high, or at any time before the next strobe, because they hold their value until then.

Top module: `serial_rx_frame`

## Requirements
- R1: While `rst` is high and right after it is released, `rx_valid`, `par_err` and `frm_err` are 0 and `rx_data` is all zeros.
- R2: A character starts only on a high-to-low change of the synchronised line while idle. A line that stays low without first going high starts nothing.
- R3: The start bit is sampled again at its mid-point. If the line is high there, the receiver returns to idle and produces no strobe.
- R4: The seven data bits are sampled at their mid-points and arrive least significant bit first, so the first data bit received appears at `rx_data[0]`.
- R5: `rx_valid` is high for exactly one clock per accepted character. Suppose the start bit is placed on `rx_line` just before clock edge 0. Then the strobe is visible after edge `BIT_CLKS/2 + 2 + 9*BIT_CLKS` (two synchroniser edges, one edge-detect edge, then half a period, then nine full periods).
- R6: `par_err` is 1 when the parity of the seven data bits and the parity bit together does not match the mode. The mode pin `odd_sel` selects the parity sense: 1 means odd, where the count of ones is odd, and 0 means even.
- R7: `frm_err` is 1 when the line is low at the stop bit's mid-point sample. The character and its parity result are still delivered with the strobe.
- R8: A start bit that follows the stop bit with no idle time in between is detected, and its character is received correctly.
- R9: `rx_data`, `par_err` and `frm_err` change only in a cycle where `rx_valid` is high, and hold their value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial line, idle high |
| odd_sel | input | 1 | Parity sense: 1 odd, 0 even |
| rx_data | output | DATA_BITS | Last received character |
| rx_valid | output | 1 | One-clock strobe when a character is complete |
| par_err | output | 1 | Parity mismatch on the last character |
| frm_err | output | 1 | Stop bit was low on the last character |

## Verification
The hardest situations to reach from the ports are a start edge that arrives with no idle time after a stop bit, and a short low pulse that must be rejected at the start bit's mid-point. Both are placed precisely by a bench transmitter that drives the line one bit period at a time on the falling clock edge. In the back-to-back case, the next start bit is driven on the edge right after the stop period ends. In the glitch case, the line is held low for only three clocks. A frame with a low stop bit is followed by a long low stretch, which shows that no new character starts until the line has gone high again.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_PAR   = 3'd3,
    RX_STOP  = 3'd4
  } rx_state_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_timer.sv
module serial_rx_timer #(
  parameter int BIT_CLKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic tick
);
  localparam int CW   = $clog2(BIT_CLKS);
  localparam int HALF = BIT_CLKS / 2;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (start)     cnt <= CW'(HALF - 1);
    else if (tick)      cnt <= CW'(BIT_CLKS - 1);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/serial_rx_shift.sv
module serial_rx_shift #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [WIDTH-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {bit_in, word[WIDTH-1:1]};
  end
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int BIT_CLKS    = 16,
  parameter int DATA_BITS   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_line,
  input  logic                 odd_sel,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 par_err,
  output logic                 frm_err
);
  localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(DATA_BITS - 1);

  rx_state_t            state;
  logic                 line_s;
  logic                 line_prev;
  logic                 fall;
  logic                 start_go;
  logic                 tick;
  logic                 shift_en;
  logic [IW-1:0]        bit_idx;
  logic                 par_bit;
  logic [DATA_BITS-1:0] word;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rx_line), .dout(line_s)
  );

  assign fall     = line_prev && !line_s;
  assign start_go = (state == RX_IDLE) && fall;
  assign shift_en = (state == RX_DATA) && tick;

  serial_rx_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
    .clk(clk), .rst(rst), .start(start_go),
    .run(state != RX_IDLE), .tick(tick)
  );

  serial_rx_shift #(.WIDTH(DATA_BITS)) u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .bit_in(line_s), .word(word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      line_prev <= 1'b1;
      bit_idx   <= '0;
      par_bit   <= 1'b0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      par_err   <= 1'b0;
      frm_err   <= 1'b0;
    end else begin
      line_prev <= line_s;
      rx_valid  <= 1'b0;
      unique case (state)
        RX_IDLE: if (start_go) state <= RX_START;
        RX_START: if (tick) begin
          bit_idx <= '0;
          state   <= line_s ? RX_IDLE : RX_DATA;
        end
        RX_DATA: if (tick) begin
          bit_idx <= bit_idx + 1'b1;
          if (bit_idx == LAST_IDX) state <= RX_PAR;
        end
        RX_PAR: if (tick) begin
          par_bit <= line_s;
          state   <= RX_STOP;
        end
        RX_STOP: if (tick) begin
          rx_data  <= word;
          rx_valid <= 1'b1;
          par_err  <= (^word) ^ par_bit ^ odd_sel;
          frm_err  <= !line_s;
          state    <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_frame_chk.sv
module serial_rx_frame_chk
  import serial_rx_pkg::*;
#(
  parameter int DATA_BITS = 7
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 line_s,
  input rx_state_t            state,
  input logic                 rx_valid,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 par_err,
  input logic                 frm_err
);
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  p_strobe_after_stop_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_valid) |-> ($past(state) == RX_STOP));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> ($stable(rx_data) && $stable(par_err) && $stable(frm_err)));

  p_frame_err_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && frm_err) |-> !$past(line_s));

  p_start_edge_r2: assert property (@(posedge clk) disable iff (rst)
    (state == RX_START && $past(state) == RX_IDLE) |-> !$past(line_s));

  p_glitch_r3: assert property (@(posedge clk) disable iff (rst)
    (state == RX_IDLE && $past(state) == RX_START) |-> $past(line_s));
endmodule

bind serial_rx_frame serial_rx_frame_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst(rst), .line_s(line_s), .state(state),
  .rx_valid(rx_valid), .rx_data(rx_data), .par_err(par_err), .frm_err(frm_err)
);

// File: tb/serial_rx_frame_bench.sv
module serial_rx_frame_bench;
  localparam int CLK_PERIOD = 10;
  localparam int C    = 16;
  localparam int HALF = C / 2;
  localparam int DW   = 7;

  typedef struct {
    int       cyc;
    logic [DW-1:0] data;
    logic     perr;
    logic     ferr;
  } exp_t;

  logic clk = 0, rst = 1, rx_line = 1, odd_sel = 1;
  logic [DW-1:0] rx_data;
  logic rx_valid, par_err, frm_err;

  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;
  exp_t exp_q[$];
  logic [DW-1:0] held_data = '0;
  logic held_perr = 0, held_ferr = 0;

  serial_rx_frame #(.BIT_CLKS(C), .DATA_BITS(DW)) u_serial_rx_frame (
    .clk(clk), .rst(rst), .rx_line(rx_line), .odd_sel(odd_sel),
    .rx_data(rx_data), .rx_valid(rx_valid), .par_err(par_err), .frm_err(frm_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // Reference: per clock, a strobe is due exactly when the head frame's cycle arrives.
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit due;
      due = (exp_q.size() > 0) && (exp_q[0].cyc == cyc);
      chk("R5 strobe", rx_valid, due);
      if (due) begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R4 data", rx_data, e.data);
        chk("R6 parity", par_err, e.perr);
        chk("R7 framing", frm_err, e.ferr);
        held_data = e.data; held_perr = e.perr; held_ferr = e.ferr;
      end else begin
        chk("R9 hold", {frm_err, par_err, rx_data}, {held_ferr, held_perr, held_data});
      end
    end
  end

  task automatic idle(int n);
    rx_line = 1;
    repeat (n) @(negedge clk);
  endtask

  // Sends one frame starting at a falling clock edge; ends on the stop period's end.
  task automatic send(logic [DW-1:0] d, bit bad_par, bit stop_v);
    logic [9:0] bits;
    logic p;
    exp_t e;
    p = odd_sel ? ~^d : ^d;
    if (bad_par) p = ~p;
    bits = {stop_v, p, d, 1'b0};
    e.cyc = cyc + HALF + 3 + 9 * C;
    e.data = d; e.perr = bad_par; e.ferr = !stop_v;
    exp_q.push_back(e);
    for (int b = 0; b < 10; b++) begin
      rx_line = bits[b];
      repeat (C) @(negedge clk);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 reset", {rx_valid, par_err, frm_err, rx_data}, '0);
    rst = 0;
    @(negedge clk);
    chk("R1 after reset", {rx_valid, par_err, frm_err, rx_data}, '0);
    idle(20);
    // R4 R6 odd mode, assorted patterns
    send(7'h57, 0, 1); idle(5);
    send(7'h00, 0, 1); idle(7);
    send(7'h7F, 0, 1); idle(3);
    send(7'h2A, 0, 1); idle(11);
    // R8 back-to-back frames, no idle between stop and start
    send(7'h01, 0, 1);
    send(7'h40, 0, 1);
    send(7'h35, 0, 1); idle(9);
    // R6 bad parity in odd mode
    send(7'h5A, 1, 1); idle(6);
    // R6 even mode
    odd_sel = 0; idle(4);
    send(7'h15, 0, 1); idle(5);
    send(7'h63, 1, 1); idle(5);
    // R7 missing stop bit, then R2: line stays low, no new character
    send(7'h3C, 0, 0);
    rx_line = 0; repeat (3 * C) @(negedge clk);
    idle(2 * C);
    // R3 short low pulse rejected at start mid-point
    rx_line = 0; repeat (3) @(negedge clk);
    idle(2 * C);
    send(7'h66, 0, 1); idle(2 * C);
    chk("R5 all frames delivered", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog cyc=%0d actual=running expected=finished", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule